// File: doc/BRIEF.md
# Closed-Loop Frequency-Lock Tuner

This block is the digital control loop for a digitally controlled oscillator. It counts oscillator cycles over each reference-clock period and takes the difference from a programmed multiplication target. From that signed error it drives a coarse code and a fine code back to the oscillator. While it is enabled, locking runs in two stages. A binary search first settles the coarse code. A step search with a shrinking step then settles the fine code. After fine lock, the tuner can keep nudging the fine code to follow drift, or it can freeze the fine code.

All control logic runs on the system clock. The reference and the oscillator clocks reach the block as asynchronous inputs, and the block synchronises both. The host controls the block through a small set of register-style ports: a target write strobe with its data, an enable, and a stable bit. It reads back the codes, the last ratio difference, the ready and lock status bits, and one single-cycle interrupt pulse per lock bit. A reference period counts as one measurement window. The first window that completes after any code change is thrown away so that the oscillator can settle.

Top module: `freq_lock_tuner`

## Requirements
- R1: While disabled (en_i low) and after reset, coarse_o is 16 (only bit 4 set), fine_o is 128, ratio_diff_o is 0, and all status and interrupt outputs are low.
- R2: ready_o rises when the first full reference period after enable completes, which is the second reference rising edge after en_i goes high. It does not depend on the lock bits. It clears in the cycle after en_i goes low.
- R3: After every completed window, ratio_diff_o holds the oscillator cycle count minus the target, as a two's-complement value. It is positive when the oscillator runs too fast.
- R4: The coarse stage tries bits 4 down to 0. Each bit starts set. The bit is cleared if the ratio difference is positive and kept otherwise. Coarse lock is set once bit 0 is decided, and the coarse code then stays fixed until the next target write or disable.
- R5: The fine stage starts at 128 with a step of 64. It moves up when the difference is negative and down when it is positive, and the step halves on each change of direction. Fine lock is set when |difference| <= 1, when the step is 1, or when the code sits at its limit in the requested direction. Fine lock is never set without coarse lock.
- R6: irq_coarse_o and irq_fine_o each pulse high for exactly one cycle on every 0-to-1 transition of their lock bit, and at no other time.
- R7: A target write while enabled clears both lock bits, sets coarse_o to 16 and fine_o to 128 in the next cycle, and restarts the search from the coarse stage.
- R8: With stable_i low and fine lock held, each valid measurement with |difference| > 1 moves fine_o by one step against the error. Both lock bits stay set.
- R9: With stable_i high and fine lock held, fine_o does not change.
- R10: The first window that completes after any code change produces no code decision. The coarse lock therefore rises on the tenth reference rising edge after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| osc_clk_i | input | 1 | Oscillator output clock, asynchronous |
| en_i | input | 1 | Closed-loop enable |
| stable_i | input | 1 | 1 freezes the fine code after fine lock |
| mul_we_i | input | 1 | Target write strobe |
| mul_wdata_i | input | CNT_W | Target cycles per reference period |
| coarse_o | output | C_W | Coarse oscillator code |
| fine_o | output | F_W | Fine oscillator code |
| ratio_diff_o | output | CNT_W+1 | Signed last count minus target |
| lock_coarse_o | output | 1 | Coarse lock status |
| lock_fine_o | output | 1 | Fine lock status |
| ready_o | output | 1 | First full measurement done |
| irq_coarse_o | output | 1 | Pulse on coarse lock rise |
| irq_fine_o | output | 1 | Pulse on fine lock rise |

## Verification
The bench counts reference edges from enable and checks ready and coarse lock in exact windows. A design that kept the first window after enable would raise ready one period early. A design that did not discard settling windows would lock at edge 6, not edge 10. The bench picks targets that leave at least two counts of margin on either side of the coarse decision, so a sign error in the search or a wrong keep/clear rule lands on the wrong coarse code. It then drifts the oscillator model with stable high and with stable low. A tuner that drops a lock during drift fails, and so does one that ignores the stable bit or freezes when it should track. A target write in the middle of a lock must re-centre the codes in the next cycle, and a level-type interrupt shows up as extra pulses in the counts.

// File: rtl/flt_pkg.sv
`timescale 1ns/1ps
package flt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COARSE,
    ST_FINE,
    ST_TRACK
  } stage_e;
endpackage

// File: rtl/flt_ref_sync.sv
`timescale 1ns/1ps
// Reference edge -> toggle -> synchroniser -> one-cycle tick in clk_i domain
module flt_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  output logic tick_o
);
  logic             ref_tgl_q;
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_tgl_q <= 1'b0;
    else         ref_tgl_q <= ~ref_tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ref_tgl_q};
  end

  assign tick_o = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/flt_osc_count.sv
`timescale 1ns/1ps
// Counts oscillator rising edges between reference ticks
module flt_osc_count #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             osc_clk_i,
  input  logic             tick_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_cnt_o
);
  logic [SYNC_STAGES:0] osc_q;
  logic                 osc_rise;
  logic [CNT_W-1:0]     cnt_q, cnt_inc;
  logic                 armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_q <= '0;
    else         osc_q <= {osc_q[SYNC_STAGES-1:0], osc_clk_i};
  end

  assign osc_rise = osc_q[SYNC_STAGES-1] & ~osc_q[SYNC_STAGES];
  assign cnt_inc  = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(osc_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_vld_o <= 1'b0;
      meas_cnt_o <= '0;
    end else if (!en_i) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_vld_o <= 1'b0;
    end else if (tick_i) begin
      meas_cnt_o <= cnt_inc;
      meas_vld_o <= armed_q;   // first tick after enable only opens a window
      armed_q    <= 1'b1;
      cnt_q      <= '0;
    end else begin
      cnt_q      <= cnt_inc;
      meas_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/flt_rise_pulse.sv
`timescale 1ns/1ps
module flt_rise_pulse #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] pulse_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= level_i[g];
    end
    assign pulse_o[g] = level_i[g] & ~prev_q;
  end
endmodule

// File: rtl/flt_ctrl.sv
`timescale 1ns/1ps
module flt_ctrl
  import flt_pkg::*;
#(
  parameter int C_W   = 5,
  parameter int F_W   = 8,
  parameter int CNT_W = 12,
  parameter int TOL   = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    stable_i,
  input  logic                    mul_we_i,
  input  logic [CNT_W-1:0]        mul_wdata_i,
  input  logic                    meas_vld_i,
  input  logic [CNT_W-1:0]        meas_cnt_i,
  output logic [C_W-1:0]          coarse_o,
  output logic [F_W-1:0]          fine_o,
  output logic signed [CNT_W:0]   diff_o,
  output logic                    lock_c_o,
  output logic                    lock_f_o,
  output logic                    ready_o
);
  localparam int DIFF_W = CNT_W + 1;
  localparam int BIT_W  = $clog2(C_W);
  localparam logic [C_W-1:0]   C_START = C_W'(1) << (C_W - 1);
  localparam logic [F_W-1:0]   F_MID   = F_W'(1) << (F_W - 1);
  localparam logic [F_W-1:0]   STEP0   = F_W'(1) << (F_W - 2);
  localparam logic [F_W-1:0]   F_MAX   = '1;
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(C_W - 1);
  localparam logic signed [DIFF_W-1:0] TOL_S = DIFF_W'(TOL);

  stage_e             stage_q, stage_d;
  logic [C_W-1:0]     coarse_q, coarse_d;
  logic [F_W-1:0]     fine_q, fine_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [F_W-1:0]     step_q, step_d, step_n;
  logic               dir_up_q, dir_up_d, dir_vld_q, dir_vld_d;
  logic               skip_q, skip_d;
  logic               lock_c_q, lock_c_d, lock_f_q, lock_f_d;
  logic               ready_q, ready_d;
  logic signed [DIFF_W-1:0] diff, diff_q, diff_d;
  logic [CNT_W-1:0]   mul_q;
  logic               too_fast, too_slow, near, at_bound;

  assign diff     = $signed({1'b0, meas_cnt_i}) - $signed({1'b0, mul_q});
  assign too_slow = diff[DIFF_W-1];
  assign too_fast = !diff[DIFF_W-1] && (diff != '0);
  assign near     = (diff <= TOL_S) && (diff >= -TOL_S);
  assign at_bound = too_slow ? (fine_q == F_MAX) : (fine_q == '0);
  assign step_n   = (dir_vld_q && (too_slow != dir_up_q)) ? (step_q >> 1) : step_q;

  always_comb begin
    stage_d   = stage_q;
    coarse_d  = coarse_q;
    fine_d    = fine_q;
    bit_d     = bit_q;
    step_d    = step_q;
    dir_up_d  = dir_up_q;
    dir_vld_d = dir_vld_q;
    skip_d    = skip_q;
    lock_c_d  = lock_c_q;
    lock_f_d  = lock_f_q;
    ready_d   = ready_q;
    diff_d    = diff_q;
    if (!en_i) begin
      stage_d   = ST_IDLE;
      coarse_d  = C_START;
      fine_d    = F_MID;
      bit_d     = BIT_TOP;
      step_d    = STEP0;
      dir_vld_d = 1'b0;
      skip_d    = 1'b0;
      lock_c_d  = 1'b0;
      lock_f_d  = 1'b0;
      ready_d   = 1'b0;
      diff_d    = '0;
    end else if (mul_we_i) begin
      stage_d   = ST_COARSE;
      coarse_d  = C_START;
      fine_d    = F_MID;
      bit_d     = BIT_TOP;
      step_d    = STEP0;
      dir_vld_d = 1'b0;
      skip_d    = 1'b1;
      lock_c_d  = 1'b0;
      lock_f_d  = 1'b0;
    end else begin
      if (stage_q == ST_IDLE) stage_d = ST_COARSE;
      if (meas_vld_i) begin
        diff_d  = diff;
        ready_d = 1'b1;
        if (skip_q) begin
          skip_d = 1'b0;            // settling window, no decision
        end else begin
          unique case (stage_q)
            ST_COARSE: begin
              if (too_fast) coarse_d = coarse_d & ~(C_W'(1) << bit_q);
              if (bit_q == '0) begin
                lock_c_d = 1'b1;
                stage_d  = ST_FINE;
              end else begin
                bit_d    = bit_q - BIT_W'(1);
                coarse_d = coarse_d | (C_W'(1) << (bit_q - BIT_W'(1)));
              end
              skip_d = 1'b1;
            end
            ST_FINE: begin
              if (near || (step_q == F_W'(1)) || at_bound) begin
                lock_f_d = 1'b1;
                stage_d  = ST_TRACK;
              end else begin
                step_d    = step_n;
                dir_up_d  = too_slow;
                dir_vld_d = 1'b1;
                if (too_slow) fine_d = ((F_MAX - fine_q) < step_n) ? F_MAX : fine_q + step_n;
                else          fine_d = (fine_q < step_n) ? '0 : fine_q - step_n;
                skip_d    = 1'b1;
              end
            end
            ST_TRACK: begin
              if (!stable_i && !near) begin
                if (too_slow && fine_q != F_MAX) begin
                  fine_d = fine_q + F_W'(1);
                  skip_d = 1'b1;
                end else if (too_fast && fine_q != '0) begin
                  fine_d = fine_q - F_W'(1);
                  skip_d = 1'b1;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= ST_IDLE;
      coarse_q  <= C_START;
      fine_q    <= F_MID;
      bit_q     <= BIT_TOP;
      step_q    <= STEP0;
      dir_up_q  <= 1'b0;
      dir_vld_q <= 1'b0;
      skip_q    <= 1'b0;
      lock_c_q  <= 1'b0;
      lock_f_q  <= 1'b0;
      ready_q   <= 1'b0;
      diff_q    <= '0;
      mul_q     <= '0;
    end else begin
      stage_q   <= stage_d;
      coarse_q  <= coarse_d;
      fine_q    <= fine_d;
      bit_q     <= bit_d;
      step_q    <= step_d;
      dir_up_q  <= dir_up_d;
      dir_vld_q <= dir_vld_d;
      skip_q    <= skip_d;
      lock_c_q  <= lock_c_d;
      lock_f_q  <= lock_f_d;
      ready_q   <= ready_d;
      diff_q    <= diff_d;
      if (mul_we_i) mul_q <= mul_wdata_i;
    end
  end

  assign coarse_o = coarse_q;
  assign fine_o   = fine_q;
  assign diff_o   = diff_q;
  assign lock_c_o = lock_c_q;
  assign lock_f_o = lock_f_q;
  assign ready_o  = ready_q;
endmodule

// File: rtl/freq_lock_tuner.sv
`timescale 1ns/1ps
module freq_lock_tuner #(
  parameter int C_W         = 5,
  parameter int F_W         = 8,
  parameter int CNT_W       = 12,
  parameter int TOL         = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_clk_i,
  input  logic                  osc_clk_i,
  input  logic                  en_i,
  input  logic                  stable_i,
  input  logic                  mul_we_i,
  input  logic [CNT_W-1:0]      mul_wdata_i,
  output logic [C_W-1:0]        coarse_o,
  output logic [F_W-1:0]        fine_o,
  output logic signed [CNT_W:0] ratio_diff_o,
  output logic                  lock_coarse_o,
  output logic                  lock_fine_o,
  output logic                  ready_o,
  output logic                  irq_coarse_o,
  output logic                  irq_fine_o
);
  logic             tick;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  logic [1:0]       irq_vec;

  flt_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .tick_o    (tick)
  );

  flt_osc_count #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_osc_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .osc_clk_i  (osc_clk_i),
    .tick_i     (tick),
    .meas_vld_o (meas_vld),
    .meas_cnt_o (meas_cnt)
  );

  flt_ctrl #(.C_W(C_W), .F_W(F_W), .CNT_W(CNT_W), .TOL(TOL)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .stable_i    (stable_i),
    .mul_we_i    (mul_we_i),
    .mul_wdata_i (mul_wdata_i),
    .meas_vld_i  (meas_vld),
    .meas_cnt_i  (meas_cnt),
    .coarse_o    (coarse_o),
    .fine_o      (fine_o),
    .diff_o      (ratio_diff_o),
    .lock_c_o    (lock_coarse_o),
    .lock_f_o    (lock_fine_o),
    .ready_o     (ready_o)
  );

  flt_rise_pulse #(.N(2)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i ({lock_fine_o, lock_coarse_o}),
    .pulse_o (irq_vec)
  );

  assign irq_coarse_o = irq_vec[0];
  assign irq_fine_o   = irq_vec[1];
endmodule

// File: rtl/freq_lock_tuner_chk.sv
`timescale 1ns/1ps
module freq_lock_tuner_chk #(
  parameter int C_W = 5,
  parameter int F_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           stable_i,
  input logic           mul_we_i,
  input logic [C_W-1:0] coarse_o,
  input logic [F_W-1:0] fine_o,
  input logic           lock_coarse_o,
  input logic           lock_fine_o,
  input logic           ready_o,
  input logic           irq_coarse_o,
  input logic           irq_fine_o
);
  localparam logic [C_W-1:0] C_START = C_W'(1) << (C_W - 1);
  localparam logic [F_W-1:0] F_MID   = F_W'(1) << (F_W - 1);

  a_r2_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ready_o && !lock_coarse_o && !lock_fine_o));

  a_r4_coarse_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lock_coarse_o && !mul_we_i) |=> $stable(coarse_o));

  a_r5_fine_needs_coarse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_fine_o |-> lock_coarse_o);

  a_r6_irq_coarse_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_coarse_o) |-> irq_coarse_o);

  a_r6_irq_coarse_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_coarse_o |-> $rose(lock_coarse_o));

  a_r6_irq_fine_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_fine_o) |-> irq_fine_o);

  a_r6_irq_fine_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_fine_o |-> $rose(lock_fine_o));

  a_r7_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mul_we_i) |=> (!lock_coarse_o && !lock_fine_o && fine_o == F_MID && coarse_o == C_START));

  a_r8_locks_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lock_fine_o && !mul_we_i) |=> (lock_fine_o && lock_coarse_o));

  a_r8_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lock_fine_o && !mul_we_i) |=>
      (F_W'(fine_o - $past(fine_o)) == F_W'(0) ||
       F_W'(fine_o - $past(fine_o)) == F_W'(1) ||
       F_W'($past(fine_o) - fine_o) == F_W'(1)));

  a_r9_fine_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stable_i && lock_fine_o && !mul_we_i) |=> $stable(fine_o));
endmodule

bind freq_lock_tuner freq_lock_tuner_chk #(.C_W(C_W), .F_W(F_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .stable_i      (stable_i),
  .mul_we_i      (mul_we_i),
  .coarse_o      (coarse_o),
  .fine_o        (fine_o),
  .lock_coarse_o (lock_coarse_o),
  .lock_fine_o   (lock_fine_o),
  .ready_o       (ready_o),
  .irq_coarse_o  (irq_coarse_o),
  .irq_fine_o    (irq_fine_o)
);

// File: tb/freq_lock_tuner_test.sv
`timescale 1ns/1ps
module freq_lock_tuner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        en = 1'b0;
  logic        stable = 1'b1;
  logic        mul_we = 1'b0;
  logic [11:0] mul_wdata = '0;
  logic [4:0]  coarse;
  logic [7:0]  fine;
  logic signed [12:0] ratio_diff;
  logic        lock_c, lock_f, ready, irq_c, irq_f;

  int  n_chk = 0;
  int  n_fail = 0;
  int  irq_c_cnt = 0;
  int  irq_f_cnt = 0;
  real drift_mhz = 0.0;
  int  cur_mul = 0;

  freq_lock_tuner uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .osc_clk_i(osc_clk),
    .en_i(en), .stable_i(stable), .mul_we_i(mul_we), .mul_wdata_i(mul_wdata),
    .coarse_o(coarse), .fine_o(fine), .ratio_diff_o(ratio_diff),
    .lock_coarse_o(lock_c), .lock_fine_o(lock_f), .ready_o(ready),
    .irq_coarse_o(irq_c), .irq_fine_o(irq_f)
  );

  // oscillator model: MHz rises with both codes
  function automatic real osc_mhz(int c, int f, real d);
    return 8.0 + c + f / 128.0 + d;
  endfunction
  // expected count over one 8 us reference period
  function automatic real model_cnt(int c, int f, real d);
    return 8.0 * osc_mhz(c, f, d);
  endfunction
  function automatic int mk_target(int k, int off);
    return 72 + 8 * k + off;
  endfunction

  always #4 clk = ~clk;
  always #4000 ref_clk = ~ref_clk;
  initial forever #(500.0 / osc_mhz(int'(coarse), int'(fine), drift_mhz)) osc_clk = ~osc_clk;

  always @(negedge clk) begin
    if (irq_c) irq_c_cnt++;
    if (irq_f) irq_f_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(posedge ref_clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic write_mul(input int v);
    @(negedge clk);
    mul_we = 1'b1; mul_wdata = 12'(v);
    @(negedge clk);
    mul_we = 1'b0;
    cur_mul = v;
  endtask

  task automatic enable_aligned();
    @(posedge ref_clk);
    repeat (50) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic wait_fine_lock();
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (lock_f) break;
    end
  endtask

  task automatic check_idle(input string req);
    chk(coarse == 5'd16, req, int'(coarse), 16);
    chk(fine == 8'd128, req, int'(fine), 128);
    chk(!lock_c && !lock_f && !ready && !irq_c && !irq_f, req,
        int'({lock_c, lock_f, ready, irq_c, irq_f}), 0);
    chk(ratio_diff == 0, req, int'(ratio_diff), 0);
  endtask

  task automatic check_fine_result(input string req);
    real err;
    err = model_cnt(int'(coarse), int'(fine), drift_mhz) - cur_mul;
    chk(lock_f && lock_c, req, int'({lock_c, lock_f}), 3);
    chk(err <= 2.0 && err >= -2.0, req,
        $rtoi(model_cnt(int'(coarse), int'(fine), drift_mhz)), cur_mul);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int saved_fine, exp_irq, k, off, v;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 after reset");

    // directed lock, k=12 off=4 -> target 172
    stable = 1'b1;
    write_mul(mk_target(12, 4));
    repeat (2) @(negedge clk);
    check_idle("R1 write while disabled");
    enable_aligned();
    ref_wait(1);
    chk(!ready, "R2 ready early", int'(ready), 0);
    ref_wait(1);
    chk(ready, "R2 ready after one period", int'(ready), 1);
    chk(!lock_c, "R2 ready independent of lock", int'(lock_c), 0);
    v = $rtoi(model_cnt(16, 128, 0.0)) - cur_mul;
    chk(ratio_diff >= v - 1 && ratio_diff <= v + 1, "R3 ratio diff", int'(ratio_diff), v);
    ref_wait(7);
    chk(!lock_c, "R10 no coarse lock at edge 9", int'(lock_c), 0);
    ref_wait(1);
    chk(lock_c, "R10 coarse lock at edge 10", int'(lock_c), 1);
    chk(coarse == 5'd12, "R4 coarse search result", int'(coarse), 12);
    chk(irq_c_cnt == 1, "R6 coarse irq count", irq_c_cnt, 1);
    wait_fine_lock();
    check_fine_result("R5 fine lock");
    chk(coarse == 5'd12, "R4 coarse held", int'(coarse), 12);
    repeat (3) @(negedge clk);
    chk(irq_f_cnt == 1, "R6 fine irq count", irq_f_cnt, 1);
    ref_wait(2);
    v = $rtoi(model_cnt(int'(coarse), int'(fine), 0.0) + 0.5) - cur_mul;
    chk(ratio_diff >= v - 2 && ratio_diff <= v + 2, "R3 ratio diff locked", int'(ratio_diff), v);

    // drift with stable=1: frozen
    saved_fine = int'(fine);
    drift_mhz = 0.5;
    ref_wait(6);
    chk(int'(fine) == saved_fine, "R9 fine frozen", int'(fine), saved_fine);
    chk(lock_c && lock_f, "R9 locks held", int'({lock_c, lock_f}), 3);
    chk(ratio_diff >= 2, "R3 ratio diff positive under drift", int'(ratio_diff), 4);

    // drift with stable=0: tracking
    @(negedge clk) stable = 1'b0;
    ref_wait(8);
    chk(int'(fine) < saved_fine, "R8 fine tracks drift down", int'(fine), saved_fine - 1);
    chk(lock_c && lock_f, "R8 locks kept while tracking", int'({lock_c, lock_f}), 3);
    chk(irq_c_cnt == 1 && irq_f_cnt == 1, "R6 no extra irq while tracking", irq_c_cnt + irq_f_cnt, 2);
    drift_mhz = 0.0;
    @(negedge clk) stable = 1'b1;

    // target write while enabled
    write_mul(mk_target(7, 3));
    chk(!lock_c && !lock_f, "R7 locks cleared", int'({lock_c, lock_f}), 0);
    chk(fine == 8'd128, "R7 fine recentred", int'(fine), 128);
    chk(coarse == 5'd16, "R7 coarse restart", int'(coarse), 16);
    wait_fine_lock();
    chk(coarse == 5'd7, "R4 coarse after rewrite", int'(coarse), 7);
    check_fine_result("R5 fine after rewrite");
    repeat (3) @(negedge clk);
    chk(irq_c_cnt == 2 && irq_f_cnt == 2, "R6 irq once per relock", irq_c_cnt + irq_f_cnt, 4);
    exp_irq = 2;

    // random targets
    for (int it = 0; it < 2; it++) begin
      @(negedge clk) en = 1'b0;
      @(negedge clk);
      check_idle("R1 disabled");
      chk(!ready, "R2 ready cleared on disable", int'(ready), 0);
      k   = 3 + int'($urandom_range(21));
      off = 2 + int'($urandom_range(4));
      stable = 1'($urandom_range(1));
      write_mul(mk_target(k, off));
      enable_aligned();
      wait_fine_lock();
      exp_irq++;
      chk(int'(coarse) == k, "R4 random coarse", int'(coarse), k);
      check_fine_result("R5 random fine");
      repeat (3) @(negedge clk);
      chk(irq_c_cnt == exp_irq, "R6 random coarse irq", irq_c_cnt, exp_irq);
      chk(irq_f_cnt == exp_irq, "R6 random fine irq", irq_f_cnt, exp_irq);
    end

    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check_idle("R1 final disable");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule